// File: doc/BRIEF.md
# Byte-Lane Synchronous Memory Port

This block is one access port onto a synchronous static word array. Every request input is captured on the rising clock edge: the address, the write word, the two chip-select terms, the per-byte lane selects and the read/write strobe. A write updates only the byte lanes the request selected. A read returns the addressed word. A runtime mode input sets when that word reaches the output. In flow-through mode it appears right after the edge that registered the request. In pipelined mode it appears one edge later.

The output does not use real tri-state nets. It is a data bus plus one drive-enable bit per byte lane. A lane that is not driven reads as zero on the data bus. An active-low output enable gates the drive-enables combinationally, with no clock involved. The word depth is a parameter. `ADDR_W = 14` gives the full 16K-word array. The default is kept smaller so that elaboration stays light.

Top module: `bl_sync_port`

## Requirements
- R1: The port is selected only when `cs_a_n` is 0 and `cs_b` is 1. A request sampled with any other combination writes nothing and leaves both `drv_en` bits at 0 in the output cycle that belongs to it.
- R2: `lane_n[1]` (active low) selects bits 15:8 and `lane_n[0]` selects bits 7:0. A selected write changes only the lanes whose select is 0.
- R3: A read drives only its selected lanes: `drv_en[i]` equals the inverse of `lane_n[i]`. A byte of `rdata` whose lane is not driven reads 0.
- R4: With `pipe_mode` = 0 (flow-through), a read registered at edge k shows its word on `rdata` and `drv_en` from just after edge k until edge k+1.
- R5: With `pipe_mode` = 1 (pipelined), a read registered at edge k shows its result from just after edge k+1. After a deselected cycle, the outputs drive again only once a selected read has been followed by one more edge.
- R6: `oe_n` = 1 forces `drv_en` to 00 and `rdata` to 0 at once, with no clock edge. Returning `oe_n` to 0 restores the registered state.
- R7: A selected write request leaves `drv_en` at 00 in its output cycle, in both modes.
- R8: A read of an address in the request right after a write to that address returns the newly written word, in both modes.
- R9: Repeating the same read request returns the same word on every following cycle.
- R10: An edge sampled with `rst_n` = 0 clears the registered request and the pipeline stage, so `drv_en` is 00 afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for every register |
| rst_n | input | 1 | Synchronous active-low reset |
| pipe_mode | input | 1 | 0 = flow-through output, 1 = pipelined output |
| oe_n | input | 1 | Active-low output enable, takes effect without a clock |
| cs_a_n | input | 1 | Chip-select term that selects when low |
| cs_b | input | 1 | Chip-select term that selects when high |
| lane_n | input | 2 | Active-low byte-lane selects, bit 1 = upper byte |
| rd_wr | input | 1 | 1 = read request, 0 = write request |
| addr | input | ADDR_W | Word address |
| wdata | input | 16 | Write word |
| rdata | output | 16 | Read word, lanes that are not driven read 0 |
| drv_en | output | 2 | Per-lane drive enable, bit 1 = upper byte |

## Verification
Two functions can land on the same clock edge. The first is the array write of a registered write request. The second is the capture, or the combinational read, of the next request's address. The bench provokes this by issuing a read of an address in the cycle straight after a write to it, once in each output mode. It judges the result by comparing the word that comes out against the word just written, not against the old contents. A second overlap is the asynchronous output enable changing in the middle of a cycle that already holds a registered read. It is judged by sampling the outputs between clock edges, both before and after the toggle.

// File: rtl/bl_pkg.sv
`timescale 1ns/1ps
// Package bl_pkg
// Shared types for the byte-lane memory port.
// Assumes: a request is idle, a read or a write, decided once at capture time.
package bl_pkg;

    typedef enum logic [1:0] {
        REQ_IDLE  = 2'd0,
        REQ_READ  = 2'd1,
        REQ_WRITE = 2'd2
    } req_kind_e;

    typedef enum logic {
        OUT_FLOW = 1'b0,
        OUT_PIPE = 1'b1
    } out_mode_e;

endpackage

// File: rtl/bl_in_reg.sv
`timescale 1ns/1ps
// Module bl_in_reg
// Captures one request per rising edge and resolves the chip-select terms
// and the read/write strobe into a request kind. Lane selects come out
// active high.
// Assumes: inputs are stable around the rising edge; reset is synchronous.
module bl_in_reg
    import bl_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_a_n,
    input  logic              cs_b,
    input  logic [LANES-1:0]  lane_n,
    input  logic              rd_wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output req_kind_e         kind_q,
    output logic [LANES-1:0]  lanes_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q
);

    logic      selected;
    req_kind_e kind_d;

    // Purpose: turn the two select terms and the strobe into a request kind.
    always_comb begin
        selected = !cs_a_n && cs_b;
        if (!selected)
            kind_d = REQ_IDLE;
        else if (rd_wr)
            kind_d = REQ_READ;
        else
            kind_d = REQ_WRITE;
    end

    // Purpose: register the request on the rising edge; reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q  <= REQ_IDLE;
            lanes_q <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            kind_q  <= kind_d;
            lanes_q <= ~lane_n;
            addr_q  <= addr;
            wdata_q <= wdata;
        end
    end

    // A deselected sample must never become a live request.
    AST_DESEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_a_n || !cs_b) |=> (kind_q == REQ_IDLE)); // R1

endmodule

// File: rtl/bl_mem_array.sv
`timescale 1ns/1ps
// Module bl_mem_array
// Word array split into one bank per byte lane. Each bank has its own
// write enable. Reads are combinational from the read address.
// Assumes: contents are not reset; one write per edge at most.
module bl_mem_array #(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 8,
    parameter int LANES  = 2
) (
    input  logic                      clk,
    input  logic                      wr_en,
    input  logic [LANES-1:0]          wr_lanes,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [LANES*LANE_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic [LANES*LANE_W-1:0]   rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_bank
        logic [LANE_W-1:0] bank_q [DEPTH];

        // Purpose: store this lane's byte when the write selects the lane.
        always_ff @(posedge clk) begin
            if (wr_en && wr_lanes[g])
                bank_q[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
        end

        assign rd_data[g*LANE_W +: LANE_W] = bank_q[rd_addr];
    end

endmodule

// File: rtl/bl_out_stage.sv
`timescale 1ns/1ps
// Module bl_out_stage
// Output side: a pipeline register holding data and lane enables, a mode
// mux choosing flow-through or pipelined timing, and the asynchronous
// output-enable gate. Lanes that are not driven read as zero.
// Assumes: ft_lanes is already zero for idle and write requests.
module bl_out_stage
    import bl_pkg::*;
#(
    parameter int LANE_W = 8,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pipe_mode,
    input  logic                    oe_n,
    input  logic [LANES*LANE_W-1:0] ft_data,
    input  logic [LANES-1:0]        ft_lanes,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic [LANES-1:0]        drv_en
);

    logic [LANES*LANE_W-1:0] pp_data_q;
    logic [LANES-1:0]        pp_lanes_q;
    logic [LANES*LANE_W-1:0] sel_data;
    logic [LANES-1:0]        sel_lanes;

    // Purpose: hold the previous cycle's read result for pipelined timing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pp_data_q  <= '0;
            pp_lanes_q <= '0;
        end else begin
            pp_data_q  <= ft_data;
            pp_lanes_q <= ft_lanes;
        end
    end

    // Purpose: choose the output timing and apply the asynchronous enable.
    always_comb begin
        if (out_mode_e'(pipe_mode) == OUT_PIPE) begin
            sel_data  = pp_data_q;
            sel_lanes = pp_lanes_q;
        end else begin
            sel_data  = ft_data;
            sel_lanes = ft_lanes;
        end
        drv_en = oe_n ? '0 : sel_lanes;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign rdata[g*LANE_W +: LANE_W] = drv_en[g] ? sel_data[g*LANE_W +: LANE_W] : '0;
    end

    // Pipelined lanes lag the flow-through lanes by exactly one edge.
    AST_PIPE_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_mode && !oe_n) |-> (drv_en == $past(ft_lanes))); // R5

endmodule

// File: rtl/bl_sync_port.sv
`timescale 1ns/1ps
// Module bl_sync_port
// One synchronous port onto a byte-lane word array: input capture, masked
// write, selectable read latency and gated per-lane drive enables.
// Assumes: 16-bit words in two 8-bit lanes by default; ADDR_W sets depth.
module bl_sync_port
    import bl_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 8,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pipe_mode,
    input  logic                    oe_n,
    input  logic                    cs_a_n,
    input  logic                    cs_b,
    input  logic [LANES-1:0]        lane_n,
    input  logic                    rd_wr,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic [LANES-1:0]        drv_en
);

    localparam int DATA_W = LANES * LANE_W;

    req_kind_e          kind_q;
    logic [LANES-1:0]   lanes_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [DATA_W-1:0]  wdata_q;
    logic [DATA_W-1:0]  arr_rd;
    logic               arr_we;
    logic [LANES-1:0]   ft_lanes;

    bl_in_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_in (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_a_n  (cs_a_n),
        .cs_b    (cs_b),
        .lane_n  (lane_n),
        .rd_wr   (rd_wr),
        .addr    (addr),
        .wdata   (wdata),
        .kind_q  (kind_q),
        .lanes_q (lanes_q),
        .addr_q  (addr_q),
        .wdata_q (wdata_q)
    );

    // Purpose: decode the registered request into write strobe and read lanes.
    always_comb begin
        arr_we   = (kind_q == REQ_WRITE);
        ft_lanes = (kind_q == REQ_READ) ? lanes_q : '0;
    end

    bl_mem_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_mem (
        .clk      (clk),
        .wr_en    (arr_we),
        .wr_lanes (lanes_q),
        .wr_addr  (addr_q),
        .wr_data  (wdata_q),
        .rd_addr  (addr_q),
        .rd_data  (arr_rd)
    );

    bl_out_stage #(.LANE_W(LANE_W), .LANES(LANES)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .pipe_mode (pipe_mode),
        .oe_n      (oe_n),
        .ft_data   (arr_rd),
        .ft_lanes  (ft_lanes),
        .rdata     (rdata),
        .drv_en    (drv_en)
    );

    AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_a_n || !cs_b) |=> (pipe_mode || drv_en == '0)); // R1
    AST_PIPE_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_a_n || !cs_b) |=> ##1 (!pipe_mode || drv_en == '0)); // R5
    AST_LANE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        lane_n[LANES-1] |=> (pipe_mode || !drv_en[LANES-1])); // R3
    AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_wr) |=> (pipe_mode || drv_en == '0)); // R7
    AST_OE_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (rdata == '0)); // R6

endmodule

// File: tb/bl_sync_port_test.sv
`timescale 1ns/1ps
module bl_sync_port_test;

    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pipe_mode = 1'b0;
    logic          oe_n = 1'b0;
    logic          cs_a_n = 1'b1;
    logic          cs_b = 1'b0;
    logic [1:0]    lane_n = 2'b11;
    logic          rd_wr = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [15:0]   wdata = '0;
    logic [15:0]   rdata;
    logic [1:0]    drv_en;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;  // 50 MHz

    bl_sync_port #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .oe_n(oe_n),
        .cs_a_n(cs_a_n), .cs_b(cs_b), .lane_n(lane_n), .rd_wr(rd_wr),
        .addr(addr), .wdata(wdata), .rdata(rdata), .drv_en(drv_en)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_out(input string req, input logic [1:0] exp_en, input logic [15:0] exp_data);
        chk({req, " drv_en"}, {14'd0, drv_en}, {14'd0, exp_en});
        chk({req, " rdata"}, rdata, exp_data);
    endtask

    task automatic drive(input logic ca_n, input logic cb, input logic [1:0] ln,
                         input logic rw, input logic [AW-1:0] a, input logic [15:0] d);
        cs_a_n = ca_n; cs_b = cb; lane_n = ln; rd_wr = rw; addr = a; wdata = d;
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk_out("R10 reset", 2'b00, 16'h0000);
        rst_n = 1'b1;
    endtask

    task automatic t_flow_rw;
        pipe_mode = 1'b0;
        drive(0, 1, 2'b00, 0, 10'd5, 16'hA5C3);
        tick;
        chk_out("R7 flow write", 2'b00, 16'h0000);
        drive(0, 1, 2'b00, 1, 10'd5, 16'h0000);
        tick;
        chk_out("R4 R8 flow read after write", 2'b11, 16'hA5C3);
    endtask

    task automatic t_lanes;
        drive(0, 1, 2'b01, 0, 10'd5, 16'h12FF);
        tick;
        drive(0, 1, 2'b10, 1, 10'd5, 16'h0000);
        tick;
        chk_out("R3 lower lane only", 2'b01, 16'h00C3);
        drive(0, 1, 2'b00, 1, 10'd5, 16'h0000);
        tick;
        chk_out("R2 upper write", 2'b11, 16'h12C3);
        drive(0, 1, 2'b10, 0, 10'd5, 16'hFF77);
        tick;
        drive(0, 1, 2'b01, 1, 10'd5, 16'h0000);
        tick;
        chk_out("R3 upper lane only", 2'b10, 16'h1200);
        drive(0, 1, 2'b00, 1, 10'd5, 16'h0000);
        tick;
        chk_out("R2 lower write", 2'b11, 16'h1277);
    endtask

    task automatic t_desel;
        drive(1, 1, 2'b00, 1, 10'd5, 16'h0);
        tick;
        chk_out("R1 cs_a_n high", 2'b00, 16'h0000);
        drive(0, 0, 2'b00, 1, 10'd5, 16'h0);
        tick;
        chk_out("R1 cs_b low", 2'b00, 16'h0000);
        drive(1, 0, 2'b00, 0, 10'd5, 16'h0000);
        tick;
        chk_out("R1 deselected write", 2'b00, 16'h0000);
        drive(0, 1, 2'b00, 1, 10'd5, 16'h0);
        tick;
        chk_out("R1 deselected write ignored", 2'b11, 16'h1277);
    endtask

    task automatic t_oe;
        oe_n = 1'b1;
        #2;
        chk_out("R6 oe off mid-cycle", 2'b00, 16'h0000);
        oe_n = 1'b0;
        #2;
        chk_out("R6 oe back on", 2'b11, 16'h1277);
    endtask

    task automatic t_pipe;
        drive(0, 1, 2'b00, 0, 10'd6, 16'h3C3C);
        tick;
        drive(1, 0, 2'b00, 1, 10'd0, 16'h0);
        tick;
        pipe_mode = 1'b1;
        drive(0, 1, 2'b00, 1, 10'd6, 16'h0);
        tick;
        chk_out("R5 first edge after deselect", 2'b00, 16'h0000);
        drive(0, 1, 2'b00, 1, 10'd5, 16'h0);
        tick;
        chk_out("R5 pipelined read", 2'b11, 16'h3C3C);
        tick;
        chk_out("R9 hold 1", 2'b11, 16'h1277);
        tick;
        chk_out("R9 hold 2", 2'b11, 16'h1277);
        drive(0, 1, 2'b00, 0, 10'd9, 16'hBEEF);
        tick;
        chk_out("R9 hold 3", 2'b11, 16'h1277);
        drive(0, 1, 2'b00, 1, 10'd9, 16'h0);
        tick;
        chk_out("R7 pipelined write", 2'b00, 16'h0000);
        drive(1, 0, 2'b00, 1, 10'd9, 16'h0);
        tick;
        chk_out("R8 pipelined read after write", 2'b11, 16'hBEEF);
        tick;
        chk_out("R1 R5 pipelined deselect", 2'b00, 16'h0000);
    endtask

    task automatic t_mid_reset;
        drive(0, 1, 2'b00, 1, 10'd9, 16'h0);
        tick;
        tick;
        chk_out("R10 pre-reset drive", 2'b11, 16'hBEEF);
        rst_n = 1'b0;
        tick;
        chk_out("R10 reset clears pipeline", 2'b00, 16'h0000);
        pipe_mode = 1'b0;
        chk_out("R10 reset clears request", 2'b00, 16'h0000);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset;
        t_flow_rw;
        t_lanes;
        t_desel;
        t_oe;
        t_pipe;
        t_mid_reset;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog R1-timeout actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule